// File: doc/BRIEF.md
# Pulse-Distance Infrared Remote Decoder

This block turns a demodulated, active-high infrared remote-control pulse stream into key codes. The carrier has already been removed upstream, so the input is high during each burst ("mark") and low in between ("space"). The block times every mark and space with a tick counter. It first recognises a long leader. It then recovers 32 bits from the spacing between marks and checks that the second and fourth bytes are the bitwise inverse of the first and third. When the check passes, it presents an 8-bit device code and an 8-bit command.

A remote that keeps a key pressed sends short repeat bursts instead of the full word. The decoder reports such a burst as a repeat only while a recent accepted frame or repeat vouches for it. Any interval that falls outside its tolerance band abandons the frame and raises an error pulse. The block is fed from an input pin and drives a key-event consumer. All timing is counted in ticks of `TICK_US` microseconds, and each tick is derived from the system clock by `CLK_PER_TICK`.

Top module: `ir_pd_decoder`

## Requirements
- R1: A full frame starts with a 9 ms mark followed by a 4.5 ms space. It carries 32 bits and is closed by a 0.56 ms stop mark. The result appears as a one-cycle `valid_o` pulse after the stop mark ends.
- R2: Every bit is a 0.56 ms mark followed by a space. A 0.565 ms space encodes 0 and a 1.69 ms space encodes 1. Bits arrive least significant first. Bits 7:0 are the device code, 15:8 its inverse, 23:16 the command and 31:24 its inverse.
- R3: Every measured mark or space is accepted when it lies within ±20 % of its nominal length.
- R4: A mark or space that ends too early, or that runs past its upper bound, produces a one-cycle `error_o` pulse. The frame is then dropped and the decoder waits for the next rising edge.
- R5: When either inverse byte does not match, the decoder gives an `error_o` pulse instead of `valid_o`, and `code_o`/`data_o` keep their earlier values.
- R6: A repeat burst is a 9 ms mark, a 2.25 ms space and a 0.56 ms mark. It yields a one-cycle `repeat_o` pulse if an accepted frame or an accepted repeat ended less than 120 ms earlier. An accepted repeat restarts that 120 ms window.
- R7: A repeat burst that arrives outside that window produces no pulse on any output.
- R8: An error pulse closes the repeat window. A repeat that follows it is therefore ignored until a new frame is accepted.
- R9: At most one of `valid_o`, `repeat_o`, `error_o` is high in any cycle. `code_o` and `data_o` change only together with `valid_o`.
- R10: Reset is synchronous and active low. It clears all outputs and closes the repeat window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Demodulated IR stream, high during a burst |
| code_o | output | 8 | Device code of the last accepted frame |
| data_o | output | 8 | Command of the last accepted frame |
| valid_o | output | 1 | One-cycle pulse: new frame accepted |
| repeat_o | output | 1 | One-cycle pulse: held-key repeat accepted |
| error_o | output | 1 | One-cycle pulse: timing or inverse-byte error |

## Verification
The hardest state to reach is a live repeat window that an error has just closed. To get there, a good frame must be accepted, a frame with a corrupt inverse byte must follow well inside 120 ms, and a repeat burst must then arrive while the window would still be open without the error. The bench builds that exact sequence. It also places repeats a short and a long idle time after the window opens, so the same repeat burst is accepted in one case and ignored in the other. Tolerance edges are exercised by stretching and shrinking every interval of a whole frame by 15 %.

// File: rtl/ir_pd_pkg.sv
// Package: shared state type, nominal interval lengths and tolerance
// helpers for the pulse-distance IR decoder.
package ir_pd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LMARK,
        S_LSPACE,
        S_BMARK,
        S_BSPACE,
        S_RMARK
    } ir_state_t;

    localparam int LEAD_MARK_US  = 9000;
    localparam int LEAD_SPACE_US = 4500;
    localparam int RPT_SPACE_US  = 2250;
    localparam int MARK_US       = 560;
    localparam int ZERO_SPACE_US = 565;
    localparam int ONE_SPACE_US  = 1690;
    localparam int FRAME_BITS    = 32;

    // Lower tolerance bound of an interval, in ticks.
    function automatic int lo_ticks(int us, int tol_pct, int tick_us);
        return (us * (100 - tol_pct)) / (100 * tick_us);
    endfunction

    // Upper tolerance bound of an interval, in ticks.
    function automatic int hi_ticks(int us, int tol_pct, int tick_us);
        return (us * (100 + tol_pct)) / (100 * tick_us);
    endfunction

endpackage

// File: rtl/ir_pd_tick.sv
// Tick generator: one-cycle pulse every CLK_PER_TICK clocks.
// Assumes CLK_PER_TICK >= 1; a value of 1 makes the tick permanently high.
module ir_pd_tick #(
    parameter int CLK_PER_TICK = 2000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_PER_TICK == 1) begin : g_every
            // Every clock is a tick; clock and reset are unused here.
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick      = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(CLK_PER_TICK);
            logic [DW-1:0] div_q;

            // Divide the clock down and pulse on the terminal count.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                    tick  <= 1'b0;
                end else if (int'(div_q) == CLK_PER_TICK - 1) begin
                    div_q <= '0;
                    tick  <= 1'b1;
                end else begin
                    div_q <= div_q + 1'b1;
                    tick  <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ir_pd_sync.sv
// Input synchroniser and edge detector for the IR stream.
// Assumes ir_in is asynchronous; rise and fall share the same latency.
module ir_pd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [2:0] s_q;

    // Two synchroniser stages plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[1:0], din};
    end

    assign rise = s_q[1] & ~s_q[2];
    assign fall = ~s_q[1] & s_q[2];
endmodule

// File: rtl/ir_pd_frame.sv
// Frame engine: times marks and spaces in ticks, walks leader / bits /
// stop mark or repeat burst, assembles 32 bits LSB first, checks the
// inverse bytes. Emits one-cycle valid/error pulses and a raw repeat event.
// Assumes rise/fall come from a synchronised input and never coincide.
module ir_pd_frame
    import ir_pd_pkg::*;
#(
    parameter int TICK_US = 10,
    parameter int TOL_PCT = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rise,
    input  logic       fall,
    output logic [7:0] code_o,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       error_o,
    output logic       rpt_seen_o
);
    localparam int LM_LO = lo_ticks(LEAD_MARK_US,  TOL_PCT, TICK_US);
    localparam int LM_HI = hi_ticks(LEAD_MARK_US,  TOL_PCT, TICK_US);
    localparam int LS_LO = lo_ticks(LEAD_SPACE_US, TOL_PCT, TICK_US);
    localparam int LS_HI = hi_ticks(LEAD_SPACE_US, TOL_PCT, TICK_US);
    localparam int RS_LO = lo_ticks(RPT_SPACE_US,  TOL_PCT, TICK_US);
    localparam int RS_HI = hi_ticks(RPT_SPACE_US,  TOL_PCT, TICK_US);
    localparam int BM_LO = lo_ticks(MARK_US,       TOL_PCT, TICK_US);
    localparam int BM_HI = hi_ticks(MARK_US,       TOL_PCT, TICK_US);
    localparam int B0_LO = lo_ticks(ZERO_SPACE_US, TOL_PCT, TICK_US);
    localparam int B0_HI = hi_ticks(ZERO_SPACE_US, TOL_PCT, TICK_US);
    localparam int B1_LO = lo_ticks(ONE_SPACE_US,  TOL_PCT, TICK_US);
    localparam int B1_HI = hi_ticks(ONE_SPACE_US,  TOL_PCT, TICK_US);
    localparam int CW    = $clog2(LM_HI + 3);
    localparam int NW    = $clog2(FRAME_BITS + 1);

    ir_state_t       state;
    logic [CW-1:0]   cnt;
    logic [NW-1:0]   nbits;
    logic [31:0]     sr;
    int              lim;
    logic            over;

    function automatic logic in_rng(int v, int lo, int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // Upper bound of the interval currently being timed.
    always_comb begin
        case (state)
            S_LMARK:          lim = LM_HI;
            S_LSPACE:         lim = LS_HI;
            S_BSPACE:         lim = B1_HI;
            S_BMARK, S_RMARK: lim = BM_HI;
            default:          lim = LM_HI + 1;
        endcase
    end

    assign over = (state != S_IDLE) && (int'(cnt) > lim);

    // Sequence the frame, time each interval and produce result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cnt        <= '0;
            nbits      <= '0;
            sr         <= '0;
            code_o     <= '0;
            data_o     <= '0;
            valid_o    <= 1'b0;
            error_o    <= 1'b0;
            rpt_seen_o <= 1'b0;
        end else begin
            valid_o    <= 1'b0;
            error_o    <= 1'b0;
            rpt_seen_o <= 1'b0;
            if (tick && (cnt != '1)) cnt <= cnt + 1'b1;
            case (state)
                S_IDLE: if (rise) begin
                    state <= S_LMARK;
                    cnt   <= '0;
                end
                S_LMARK: if (fall) begin
                    cnt <= '0;
                    if (in_rng(int'(cnt), LM_LO, LM_HI)) state <= S_LSPACE;
                    else begin state <= S_IDLE; error_o <= 1'b1; end
                end
                S_LSPACE: if (rise) begin
                    cnt <= '0;
                    if (in_rng(int'(cnt), LS_LO, LS_HI)) begin
                        state <= S_BMARK;
                        nbits <= '0;
                    end else if (in_rng(int'(cnt), RS_LO, RS_HI)) begin
                        state <= S_RMARK;
                    end else begin
                        state   <= S_IDLE;
                        error_o <= 1'b1;
                    end
                end
                S_BMARK: if (fall) begin
                    cnt <= '0;
                    if (!in_rng(int'(cnt), BM_LO, BM_HI)) begin
                        state   <= S_IDLE;
                        error_o <= 1'b1;
                    end else if (int'(nbits) == FRAME_BITS) begin
                        state <= S_IDLE;
                        if ((sr[15:8] == ~sr[7:0]) && (sr[31:24] == ~sr[23:16])) begin
                            code_o  <= sr[7:0];
                            data_o  <= sr[23:16];
                            valid_o <= 1'b1;
                        end else begin
                            error_o <= 1'b1;
                        end
                    end else begin
                        state <= S_BSPACE;
                    end
                end
                S_BSPACE: if (rise) begin
                    cnt <= '0;
                    if (in_rng(int'(cnt), B0_LO, B0_HI)) begin
                        sr    <= {1'b0, sr[31:1]};
                        nbits <= nbits + 1'b1;
                        state <= S_BMARK;
                    end else if (in_rng(int'(cnt), B1_LO, B1_HI)) begin
                        sr    <= {1'b1, sr[31:1]};
                        nbits <= nbits + 1'b1;
                        state <= S_BMARK;
                    end else begin
                        state   <= S_IDLE;
                        error_o <= 1'b1;
                    end
                end
                S_RMARK: if (fall) begin
                    cnt   <= '0;
                    state <= S_IDLE;
                    if (in_rng(int'(cnt), BM_LO, BM_HI)) rpt_seen_o <= 1'b1;
                    else                                 error_o    <= 1'b1;
                end
                default: state <= S_IDLE;
            endcase
            if (over) begin
                state   <= S_IDLE;
                error_o <= 1'b1;
            end
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (int'(cnt) <= LM_HI + 1));

    // R2
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(nbits) <= FRAME_BITS);

    // R1
    valid_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(state) == S_BMARK) && (state == S_IDLE));

    // R4
    error_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (state == S_IDLE));
endmodule

// File: rtl/ir_pd_hold.sv
// Repeat window: open for HOLD_TICKS ticks after each accept, closed
// by reset or by clear. Assumes accept and clear are one-cycle pulses.
module ir_pd_hold #(
    parameter int HOLD_TICKS = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic accept,
    input  logic clear,
    output logic live
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    logic [HW-1:0] age;

    // Age since the last accept, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)                            age <= HW'(HOLD_TICKS);
        else if (clear)                        age <= HW'(HOLD_TICKS);
        else if (accept)                       age <= '0;
        else if (tick && (int'(age) < HOLD_TICKS)) age <= age + 1'b1;
    end

    assign live = int'(age) < HOLD_TICKS;

    // R6
    accept_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clear) |=> live);

    // R8
    clear_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !live);
endmodule

// File: rtl/ir_pd_decoder.sv
// Top: pulse-distance IR decoder. Chains the tick generator, input
// synchroniser, frame engine and repeat window; gates repeat events.
// Assumes TICK_US divides the nominal intervals coarsely enough to time them.
module ir_pd_decoder #(
    parameter int CLK_PER_TICK = 2000,
    parameter int TICK_US      = 10,
    parameter int TOL_PCT      = 20,
    parameter int HOLD_MS      = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_in,
    output logic [7:0] code_o,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       repeat_o,
    output logic       error_o
);
    localparam int HOLD_TICKS = (HOLD_MS * 1000) / TICK_US;

    logic tick, rise, fall, rpt_seen, live;

    ir_pd_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    ir_pd_sync u_sync (
        .clk(clk), .rst_n(rst_n), .din(ir_in), .rise(rise), .fall(fall)
    );

    ir_pd_frame #(.TICK_US(TICK_US), .TOL_PCT(TOL_PCT)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rise(rise), .fall(fall),
        .code_o(code_o), .data_o(data_o), .valid_o(valid_o),
        .error_o(error_o), .rpt_seen_o(rpt_seen)
    );

    ir_pd_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .accept(valid_o | repeat_o), .clear(error_o), .live(live)
    );

    // Pass a repeat event on only while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) repeat_o <= 1'b0;
        else        repeat_o <= rpt_seen & live;
    end

    // R9
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, repeat_o, error_o}));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(code_o) && $stable(data_o)));

    // R7
    repeat_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(repeat_o)) |-> $past(live));
endmodule

// File: tb/ir_pd_decoder_tb.sv
// Scoreboard bench: the driver pushes expected events, the monitor pops
// and compares them whenever the decoder pulses an output.
module ir_pd_decoder_tb;
    localparam int T_LM = 900;   // ticks of 10 us, one tick per clock
    localparam int T_LS = 450;
    localparam int T_RS = 225;
    localparam int T_BM = 56;
    localparam int T_B0 = 56;
    localparam int T_B1 = 169;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic [7:0] code_o, data_o;
    logic       valid_o, repeat_o, error_o;

    int checks = 0;
    int errors = 0;
    int  exp_kind[$];            // 0 valid, 1 repeat, 2 error
    logic [7:0] exp_code[$];
    logic [7:0] exp_data[$];
    string      exp_req[$];

    always #2.5 clk = ~clk;

    ir_pd_decoder #(.CLK_PER_TICK(1), .TICK_US(10), .TOL_PCT(20), .HOLD_MS(120)) u_dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .code_o(code_o), .data_o(data_o),
        .valid_o(valid_o), .repeat_o(repeat_o), .error_o(error_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(int kind, logic [7:0] c, logic [7:0] d, string req);
        exp_kind.push_back(kind);
        exp_code.push_back(c);
        exp_data.push_back(d);
        exp_req.push_back(req);
    endtask

    task automatic level(logic v, int n);
        ir_in = v;
        repeat (n) @(negedge clk);
    endtask

    // Full frame; every interval scaled by pct percent.
    task automatic send_frame(logic [7:0] c, logic [7:0] cb, logic [7:0] d,
                              logic [7:0] db, int pct);
        logic [31:0] w;
        w = {db, d, cb, c};
        level(1'b1, T_LM * pct / 100);
        level(1'b0, T_LS * pct / 100);
        for (int i = 0; i < 32; i++) begin
            level(1'b1, T_BM * pct / 100);
            level(1'b0, (w[i] ? T_B1 : T_B0) * pct / 100);
        end
        level(1'b1, T_BM * pct / 100);
        ir_in = 1'b0;
    endtask

    task automatic send_repeat();
        level(1'b1, T_LM);
        level(1'b0, T_RS);
        level(1'b1, T_BM);
        ir_in = 1'b0;
    endtask

    task automatic pending_empty(string req);
        check({req, " pending events"}, exp_kind.size(), 0);
    endtask

    // Monitor: compare every output pulse with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && (valid_o || repeat_o || error_o)) begin
            int k;
            k = valid_o ? 0 : (repeat_o ? 1 : 2);
            if (exp_kind.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R7 unexpected event actual=%0d expected=none", k);
            end else begin
                int ek;
                logic [7:0] ec, ed;
                string r;
                ek = exp_kind.pop_front();
                ec = exp_code.pop_front();
                ed = exp_data.pop_front();
                r  = exp_req.pop_front();
                check({r, " event kind"}, k, ek);
                if (ek == 0 && k == 0) begin
                    check({r, " code"}, code_o, ec);
                    check({r, " data"}, data_o, ed);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10 reset state
        check("R10 outputs", {code_o, data_o, 5'b0, valid_o, repeat_o, error_o}, 32'h0);
        rst_n = 1'b1;
        level(1'b0, 20);

        // R1 R2 basic frame, LSB first
        expect_ev(0, 8'h04, 8'h5A, "R2");
        send_frame(8'h04, 8'hFB, 8'h5A, 8'hA5, 100);
        level(1'b0, 4000);
        pending_empty("R1");

        // R6 repeat inside window, then another after 90 ms
        expect_ev(1, 0, 0, "R6");
        send_repeat();
        level(1'b0, 9000);
        expect_ev(1, 0, 0, "R6 refresh");
        send_repeat();
        level(1'b0, 13000);
        pending_empty("R6");

        // R7 window expired: repeat ignored
        send_repeat();
        level(1'b0, 500);
        pending_empty("R7");

        // R5 R8 good frame, corrupt inverse, then repeat ignored
        expect_ev(0, 8'h81, 8'h3C, "R1");
        send_frame(8'h81, 8'h7E, 8'h3C, 8'hC3, 100);
        level(1'b0, 1000);
        expect_ev(2, 0, 0, "R5");
        send_frame(8'h22, 8'hDE, 8'h11, 8'hEE, 100);
        level(1'b0, 1000);
        check("R5 code held", code_o, 8'h81);
        check("R5 data held", data_o, 8'h3C);
        send_repeat();
        level(1'b0, 500);
        pending_empty("R8");

        // R4 leader mark too short
        expect_ev(2, 0, 0, "R4 short");
        level(1'b1, 600);
        level(1'b0, 1500);
        pending_empty("R4");

        // R4 bit space overruns its bound
        expect_ev(2, 0, 0, "R4 timeout");
        level(1'b1, T_LM);
        level(1'b0, T_LS);
        for (int i = 0; i < 3; i++) begin
            level(1'b1, T_BM);
            level(1'b0, T_B1);
        end
        level(1'b1, T_BM);
        level(1'b0, 600);
        pending_empty("R4");

        // R3 stretched and shrunk by 15 %
        expect_ev(0, 8'hC5, 8'h96, "R3 slow");
        send_frame(8'hC5, 8'h3A, 8'h96, 8'h69, 115);
        level(1'b0, 800);
        expect_ev(0, 8'h37, 8'h0F, "R3 fast");
        send_frame(8'h37, 8'hC8, 8'h0F, 8'hF0, 85);
        level(1'b0, 800);

        // R5 command inverse wrong
        expect_ev(2, 0, 0, "R5 data");
        send_frame(8'h10, 8'hEF, 8'h20, 8'hDE, 100);
        level(1'b0, 800);
        check("R5 code held", code_o, 8'h37);

        // R2 extreme patterns
        expect_ev(0, 8'hFF, 8'h00, "R2 ones");
        send_frame(8'hFF, 8'h00, 8'h00, 8'hFF, 100);
        level(1'b0, 800);
        expect_ev(0, 8'h00, 8'hFF, "R2 zeros");
        send_frame(8'h00, 8'hFF, 8'hFF, 8'h00, 100);
        level(1'b0, 800);
        pending_empty("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule